// File: doc/BRIEF.md
# Multiplexed ADC conversion controller

This block sits between a register bus and one analog-to-digital converter that is shared by ten inputs: eight differential pins and two fixed references, one at +10 V and one at 0 V. Software writes one 16-bit control word. That word names the input to convert, gives a mask of the inputs it regards as enabled, asks for an optional settling pause, and carries a start bit. The controller then runs the pause, if one was asked for, and drives the converter model. When the conversion is complete it stores the sample and raises a done flag.

The converter model has a fixed latency and returns an offset-binary code. The block turns that code into two's complement by inverting the top bit. The done flag can raise an interrupt and is cleared by writing 1 to it. If the selected input is not enabled in the mask, or does not exist, the conversion still runs but a sticky error flag is set.

The register map uses a 2-bit address. Address 0 is the control word. Address 1 is status: busy is bit 0, done is bit 2, error is bit 3. Address 2 is the interrupt enable, bit 2. Address 3 is the sample. Reads are combinational on the address.

Top module: `adc_mux_ctl`

## Requirements
- R1: After reset every register reads 0, busy is 0 and irq_o is low.
- R2: A write to address 0 while idle stores bits 15:1 and launches a conversion when bit 0 is 1. Bits 4:1 select the input, bits 14:5 are the enable mask for inputs 0 to 9, and bit 15 asks for the settling delay. The control word reads back with bit 0 as 0.
- R3: Without the delay, status busy (bit 0) is 1 from the edge after the write edge, and done (bit 2) rises exactly CONV_LAT+2 clock edges after the write edge. On that same edge busy falls.
- R4: With bit 15 set, done rises SETTLE_CYC edges later than it does without the delay.
- R5: Address 3 returns the raw code with bit 15 inverted. The raw code of inputs 0 to 7 is the matching 16-bit slice of analog_i (input k at bits 16k+15:16k). Input 8 gives raw 0xFFFF, so it reads 0x7FFF. Input 9 gives raw 0x8000, so it reads 0x0000.
- R6: Writing 1 to status bit 2 clears done. Writing 0 there leaves it unchanged. If a completion and a clear fall on the same edge, done ends up 1.
- R7: irq_o is high exactly while done is 1 and the enable register bit 2 is 1.
- R8: If the selected input's mask bit is 0, or the selection is 10 to 15, the conversion still completes and status bit 3 is set together with done. Out-of-range selections return raw 0x8000. Bit 3 stays set through later good conversions until 1 is written to it.
- R9: Control writes while busy are ignored: the stored word is unchanged, no restart happens, and the result and its timing belong to the original request.
- R10: The sample register keeps its value until the next completion. Clearing done does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| analog_i | input | 128 | Raw offset-binary codes of differential inputs 0 to 7 |
| rdata_o | output | 16 | Read data for addr_i |
| irq_o | output | 1 | Conversion-done interrupt |

## Verification
The hardest case to reach from the ports is a clear of done that lands on the very edge where a new conversion completes. The flag has to be already set from an earlier run and left uncleared. The bench then starts a second conversion, counts CONV_LAT+2 edges (plus SETTLE_CYC when the delay bit is set), and places the status write so that it is sampled on the completion edge. Random selections, masks and delay bits, including out-of-range inputs, exercise the error flag and both reference codes. Directed writes made during a busy window confirm that those writes are dropped.

// File: rtl/adc_mux_ctl_pkg.sv
package adc_mux_ctl_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned CH_N      = 10;
  localparam int unsigned DIFF_N    = 8;
  localparam int unsigned SEL_W     = 4;
  localparam int unsigned SEL_LSB   = 1;
  localparam int unsigned MASK_LSB  = SEL_LSB + SEL_W;
  localparam int unsigned DLY_BIT   = MASK_LSB + CH_N;
  localparam int unsigned BUSY_BIT  = 0;
  localparam int unsigned DONE_BIT  = 2;
  localparam int unsigned ERR_BIT   = 3;
  localparam logic [WORD_W-1:0] MID_CODE = WORD_W'(1) << (WORD_W - 1);

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_IEN  = 2'd2,
    A_DATA = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SETTLE,
    S_CONV
  } seq_state_e;

  typedef struct packed {
    logic             dly;
    logic [CH_N-1:0]  mask;
    logic [SEL_W-1:0] sel;
  } conv_req_t;
endpackage

// File: rtl/adc_ctl_stub.sv
module adc_ctl_stub
  import adc_mux_ctl_pkg::*;
#(
  parameter int unsigned CONV_LAT = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     go_i,
  input  logic [SEL_W-1:0]         ch_i,
  input  logic [DIFF_N*WORD_W-1:0] analog_i,
  output logic                     valid_o,
  output logic [WORD_W-1:0]        code_o
);
  localparam int unsigned CW = $clog2(CONV_LAT + 1);

  logic              active_q;
  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] code_q;
  logic [WORD_W-1:0] pick;
  logic              valid_q;

  // input 8 is full-scale positive, 9 and out-of-range are midscale
  always_comb begin
    pick = MID_CODE;
    if (ch_i == SEL_W'(DIFF_N)) pick = '1;
    for (int i = 0; i < int'(DIFF_N); i++)
      if (ch_i == SEL_W'(i)) pick = analog_i[i*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      code_q   <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (go_i) begin
        active_q <= 1'b1;
        cnt_q    <= CW'(CONV_LAT - 1);
        code_q   <= pick;
      end else if (active_q) begin
        if (cnt_q == '0) begin
          active_q <= 1'b0;
          valid_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign code_o  = code_q;

  a_r3_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
  import adc_mux_ctl_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  conv_req_t        req_i,
  input  logic             valid_i,
  output logic             busy_o,
  output logic             go_o,
  output logic [SEL_W-1:0] ch_o,
  output logic             done_set_o,
  output logic             err_set_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

  seq_state_e       state_q;
  logic [CW-1:0]    cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic             err_q;
  logic             go_q;

  function automatic logic ch_enabled(logic [SEL_W-1:0] s, logic [CH_N-1:0] m);
    logic ok;
    ok = 1'b0;
    for (int i = 0; i < int'(CH_N); i++)
      if (s == SEL_W'(i) && m[i]) ok = 1'b1;
    return ok;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      sel_q   <= '0;
      err_q   <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      go_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          sel_q <= req_i.sel;
          err_q <= !ch_enabled(req_i.sel, req_i.mask);
          if (req_i.dly) begin
            state_q <= S_SETTLE;
            cnt_q   <= CW'(SETTLE_CYC - 1);
          end else begin
            state_q <= S_CONV;
            go_q    <= 1'b1;
          end
        end
        S_SETTLE: begin
          if (cnt_q == '0) begin
            state_q <= S_CONV;
            go_q    <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_CONV: if (valid_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign go_o       = go_q;
  assign ch_o       = sel_q;
  assign done_set_o = (state_q == S_CONV) && valid_i;
  assign err_set_o  = done_set_o && err_q;

  a_r3_valid_in_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> state_q == S_CONV);
  a_r2_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r4_settle_no_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SETTLE && cnt_q != '0) |=> !go_q);
endmodule

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
  import adc_mux_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              done_set_i,
  input  logic              err_set_i,
  input  logic [WORD_W-1:0] raw_i,
  output logic              start_o,
  output conv_req_t         req_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [WORD_W-1:1] ctrl_q;
  logic              done_q;
  logic              err_q;
  logic              ien_q;
  logic [WORD_W-1:0] data_q;

  logic wr_ctrl, wr_stat, wr_ien;

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL) && !busy_i;
  assign wr_stat = wr_en_i && (addr_i == A_STAT);
  assign wr_ien  = wr_en_i && (addr_i == A_IEN);

  assign start_o = wr_ctrl && wdata_i[0];
  assign req_o   = conv_req_t'(wdata_i[DLY_BIT:SEL_LSB]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ien_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[WORD_W-1:1];
      if (wr_ien)  ien_q  <= wdata_i[DONE_BIT];
      // a completion outranks a same-edge clear
      if (done_set_i)                         done_q <= 1'b1;
      else if (wr_stat && wdata_i[DONE_BIT]) done_q <= 1'b0;
      if (err_set_i)                          err_q  <= 1'b1;
      else if (wr_stat && wdata_i[ERR_BIT])  err_q  <= 1'b0;
      if (done_set_i) data_q <= raw_i ^ MID_CODE;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o = {ctrl_q, 1'b0};
      A_STAT: begin
        rdata_o[BUSY_BIT] = busy_i;
        rdata_o[DONE_BIT] = done_q;
        rdata_o[ERR_BIT]  = err_q;
      end
      A_IEN:  rdata_o[DONE_BIT] = ien_q;
      A_DATA: rdata_o = data_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = done_q & ien_q;

  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set_i |=> done_q);
  a_r6_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[DONE_BIT] && !done_set_i) |=> !done_q);
  a_r9_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(ctrl_q));
  a_r5_msb_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set_i |=> data_q[WORD_W-1] != $past(raw_i[WORD_W-1]));
  a_r10_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_set_i |=> $stable(data_q));
  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(wr_stat && wdata_i[ERR_BIT])) |=> err_q);
endmodule

// File: rtl/adc_mux_ctl.sv
module adc_mux_ctl
  import adc_mux_ctl_pkg::*;
#(
  parameter int unsigned CONV_LAT   = 6,
  parameter int unsigned SETTLE_CYC = 20
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [1:0]               addr_i,
  input  logic [WORD_W-1:0]        wdata_i,
  input  logic [DIFF_N*WORD_W-1:0] analog_i,
  output logic [WORD_W-1:0]        rdata_o,
  output logic                     irq_o
);
  logic              start, busy, go, valid, done_set, err_set;
  conv_req_t         req;
  logic [SEL_W-1:0]  ch;
  logic [WORD_W-1:0] code;

  adc_ctl_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .busy_i     (busy),
    .done_set_i (done_set),
    .err_set_i  (err_set),
    .raw_i      (code),
    .start_o    (start),
    .req_o      (req),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o)
  );

  adc_ctl_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .req_i      (req),
    .valid_i    (valid),
    .busy_o     (busy),
    .go_o       (go),
    .ch_o       (ch),
    .done_set_o (done_set),
    .err_set_o  (err_set)
  );

  adc_ctl_stub #(.CONV_LAT(CONV_LAT)) u_stub (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .ch_i     (ch),
    .analog_i (analog_i),
    .valid_o  (valid),
    .code_o   (code)
  );

  a_r7_irq_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(done_set) || $past(wr_en_i && addr_i == A_IEN));
endmodule

// File: tb/sim_adc_mux_ctl.sv
module sim_adc_mux_ctl;
  localparam int LAT = 6;
  localparam int SET = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   addr = '0;
  logic [15:0]  wdata = '0;
  logic [127:0] analog = '0;
  logic [15:0]  rdata;
  logic         irq;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  adc_mux_ctl #(.CONV_LAT(LAT), .SETTLE_CYC(SET)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .analog_i(analog), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [15:0] exp_data(input logic [3:0] s, input logic [127:0] an);
    logic [15:0] raw;
    if (s < 4'd8)       raw = an[s*16 +: 16];
    else if (s == 4'd8) raw = 16'hFFFF;
    else                raw = 16'h8000;
    return raw ^ 16'h8000;
  endfunction

  function automatic logic exp_err(input logic [3:0] s, input logic [9:0] m);
    return (s > 4'd9) || !m[s];
  endfunction

  // R2 R3 R4 R5 R8: one full conversion with exact timing checks
  task automatic run_conv(input logic [3:0] s, input logic [9:0] m, input logic dly);
    logic [15:0] w, r;
    int n;
    wr(2'd1, 16'h000C);
    w = {dly, m, s, 1'b1};
    wr(2'd0, w);
    rd(2'd1, r); chk("R3 busy after start", r[0], 1'b1);
    rd(2'd0, r); chk("R2 ctrl readback", r, {w[15:1], 1'b0});
    n = LAT + 2 + (dly ? SET : 0);
    repeat (n - 1) @(negedge clk);
    rd(2'd1, r); chk(dly ? "R4 done not early" : "R3 done not early", r[2], 1'b0);
    @(negedge clk);
    rd(2'd1, r);
    chk(dly ? "R4 done on time" : "R3 done on time", r[2], 1'b1);
    chk("R3 busy cleared", r[0], 1'b0);
    chk("R8 error flag", r[3], exp_err(s, m));
    rd(2'd3, r); chk("R5 sample", r, exp_data(s, analog));
  endtask

  initial begin
    logic [15:0] r, keep;
    int n;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r); chk("R1 reset reg", r, 16'h0000);
    end
    chk("R1 irq reset", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 references and a differential input
    analog = {$urandom, $urandom, $urandom, $urandom};
    run_conv(4'd8, 10'h3FF, 1'b0);
    run_conv(4'd9, 10'h3FF, 1'b0);
    run_conv(4'd0, 10'h3FF, 1'b1);
    run_conv(4'd7, 10'h3FF, 1'b0);
    // R8 disabled input and out-of-range selection
    run_conv(4'd3, 10'h3F7, 1'b0);
    run_conv(4'd12, 10'h3FF, 1'b0);

    // R8 sticky through a good conversion when not cleared
    wr(2'd0, {1'b0, 10'h000, 4'd2, 1'b1});
    repeat (LAT + 3) @(negedge clk);
    rd(2'd1, r); chk("R8 error set", r[3], 1'b1);
    wr(2'd1, 16'h0004);
    wr(2'd0, {1'b0, 10'h3FF, 4'd2, 1'b1});
    repeat (LAT + 3) @(negedge clk);
    rd(2'd1, r); chk("R8 error sticky", r[3], 1'b1);
    wr(2'd1, 16'h0008);
    rd(2'd1, r); chk("R8 error w1c", r[3], 1'b0);

    // R6 writing 0 leaves done; R10 data survives clear
    rd(2'd3, keep);
    wr(2'd1, 16'h0000);
    rd(2'd1, r); chk("R6 write 0 keeps done", r[2], 1'b1);
    // R7 interrupt gating
    chk("R7 irq off without enable", irq, 1'b0);
    wr(2'd2, 16'h0004);
    chk("R7 irq on", irq, 1'b1);
    wr(2'd1, 16'h0004);
    chk("R7 irq off after clear", irq, 1'b0);
    rd(2'd1, r); chk("R6 w1c clears done", r[2], 1'b0);
    rd(2'd3, r); chk("R10 data held", r, keep);

    // R9 control write during busy is dropped
    analog = {$urandom, $urandom, $urandom, $urandom};
    wr(2'd0, {1'b0, 10'h3FF, 4'd3, 1'b1});
    wr(2'd0, {1'b1, 10'h000, 4'd5, 1'b1});
    rd(2'd0, r); chk("R9 ctrl unchanged", r, {1'b0, 10'h3FF, 4'd3, 1'b0});
    repeat (LAT - 1) @(negedge clk);
    rd(2'd1, r); chk("R9 not early", r[2], 1'b0);
    @(negedge clk);
    rd(2'd1, r); chk("R9 original timing", r[2], 1'b1);
    chk("R9 no error from dropped write", r[3], 1'b0);
    chk("R7 irq with enable", irq, 1'b1);
    rd(2'd3, r); chk("R9 original sample", r, exp_data(4'd3, analog));
    repeat (SET + LAT + 4) @(negedge clk);
    rd(2'd1, r); chk("R9 no restart", r[0], 1'b0);

    // R6 clear colliding with completion; done already 1 from before
    wr(2'd0, {1'b0, 10'h3FF, 4'd1, 1'b1});
    n = LAT + 2;
    repeat (n - 1) @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 16'h0004;
    @(negedge clk);
    wr_en = 1'b0;
    rd(2'd1, r); chk("R6 set wins over clear", r[2], 1'b1);
    rd(2'd3, r); chk("R5 collision sample", r, exp_data(4'd1, analog));

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [3:0] s;
      logic [9:0] m;
      logic dl;
      analog = {$urandom, $urandom, $urandom, $urandom};
      s  = 4'($urandom_range(0, 15));
      m  = 10'($urandom);
      dl = ($urandom_range(0, 3) == 0);
      run_conv(s, m, dl);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule